// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter with SEC-DED Encoding

This block is the transmit half of an asynchronous serial port. A processor places a byte on `din` and pulses the active-low strobe `wr_n`; the block latches the byte with the mode and length controls, drops `ready`, and sends a frame on `txd`, one bit per `baud_tick` pulse. A separate divider produces the tick. Once the stop bit has been sent, `ready` rises again and the processor may write the next word.

There are two frame types. In plain mode, `len_code` sets the payload to 5 to 8 bits. An even parity bit follows the payload. In protected mode, only the low nibble of the byte is used. It is expanded into an 8-bit extended Hamming codeword, which corrects one error and detects two. A fixed 1 fills the parity slot. Both frame types open with a 0 start bit and close with a 1 stop bit, and every field goes out least significant bit first.

Top module: `uart_sec_tx`

## Requirements
- R1: After a synchronous reset, including one that arrives in the middle of a frame, `txd` is 1 and `ready` is 1, and no frame is in progress.
- R2: A low `wr_n` sampled while `ready` is 1 captures `din`, `ecc_mode` and `len_code`. `ready` is 0 from the following cycle.
- R3: `txd` changes only on cycles where `baud_tick` is 1. The first tick after a capture starts the 0 start bit, and each later tick moves to the next bit.
- R4: With `ecc_mode`=0, `len_code` 00/01/10/11 sends 5/6/7/8 payload bits, taken from `din[0]` upward, one per tick.
- R5: In plain mode, the bit after the payload is chosen so that the payload bits plus this bit hold an even number of ones. Bits of `din` above the selected length are not sent and do not affect this parity bit.
- R6: With `ecc_mode`=1, the 8 bits sent, from bit 0 upward, are the codeword {d3,d2,d1,d0,p3,pall,p2,p1}. Here d=`din[3:0]`, p1=d0^d1^d3, p2=d0^d2^d3, p3=d1^d2^d3, and pall is the XOR of d and p1..p3. For example, data 0001 gives codeword 00010111. `len_code` and `din[7:4]` have no effect.
- R7: In protected mode the parity slot carries a 1. In both modes the stop bit is 1.
- R8: `ready` stays 0 through the stop bit and returns to 1 on the tick that ends it. `txd` is 1 whenever `ready` is 1.
- R9: A `wr_n` pulse while `ready` is 0 is ignored. The current frame continues unchanged, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Word to transmit |
| ecc_mode | input | 1 | 0 = plain frame with parity, 1 = SEC-DED codeword frame |
| len_code | input | 2 | Payload length in plain mode (5 + code) |
| txd | output | 1 | Serial line, idles high |
| ready | output | 1 | High when a new word may be written |

## Verification
The assertions check these properties on every cycle:
- `txd` is held between ticks.
- `txd` is high while `ready` is high.
- The captured word cannot change while a frame is in progress.
- A write accepted in idle always drops `ready`.
- The bit counter never passes the selected length.
- Every codeword the encoder produces has even overall parity.

Only the bench scenarios can show the following:
- the exact bit order on the line;
- the parity and codeword values;
- the stop-bit and `ready` timing at the end of a frame;
- that an intruding write leaves both the current frame and the idle line after it untouched.

// File: rtl/uart_sec_tx_pkg.sv
`timescale 1ns/1ps
package uart_sec_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LDN, ST_LDC, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;
  localparam int NIB_W = 4;
  localparam int CW_W  = 8;
endpackage

// File: rtl/secded84_enc.sv
`timescale 1ns/1ps
module secded84_enc
  import uart_sec_tx_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [CW_W-1:0]  cw
);
  logic p1, p2, p3, pall;

  always_comb begin
    p1   = nib[0] ^ nib[1] ^ nib[3];
    p2   = nib[0] ^ nib[2] ^ nib[3];
    p3   = nib[1] ^ nib[2] ^ nib[3];
    pall = (^nib) ^ p1 ^ p2 ^ p3;
    cw   = {nib, p3, pall, p2, p1};
  end

  // R6
  always_comb begin
    if (!$isunknown(nib)) begin
      cw_even_chk: assert (^cw == 1'b0);
    end
  end
endmodule

// File: rtl/tx_frame_build.sv
`timescale 1ns/1ps
module tx_frame_build
  import uart_sec_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1
)(
  input  logic [DATA_W-1:0] word,
  input  logic              ecc,
  input  logic [LEN_W-1:0]  len_code,
  output logic [DATA_W-1:0] payload,
  output logic              par_bit,
  output logic [IDX_W-1:0]  last_idx
);
  logic [IDX_W-1:0]  plain_last;
  logic [DATA_W-1:0] keep;
  logic [CW_W-1:0]   cw;

  assign plain_last = IDX_W'(MIN_LEN - 1) + IDX_W'(len_code);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign keep[g] = (IDX_W'(g) <= plain_last);
  end

  secded84_enc u_enc (
    .nib (word[NIB_W-1:0]),
    .cw  (cw)
  );

  always_comb begin
    if (ecc) begin
      payload  = DATA_W'(cw);
      par_bit  = 1'b1;
      last_idx = IDX_W'(CW_W - 1);
    end else begin
      payload  = word & keep;
      par_bit  = ^(word & keep);
      last_idx = plain_last;
    end
  end
endmodule

// File: rtl/uart_sec_tx.sv
`timescale 1ns/1ps
module uart_sec_tx
  import uart_sec_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  localparam int IDX_W = $clog2(DATA_W)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ecc_mode,
  input  logic [LEN_W-1:0]  len_code,
  output logic              txd,
  output logic              ready
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] hold_word;
  logic              hold_ecc;
  logic [LEN_W-1:0]  hold_len;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic [IDX_W-1:0]  cnt_q, last_q;
  logic              txd_q, ready_q;

  logic [DATA_W-1:0] payload;
  logic              par_bit;
  logic [IDX_W-1:0]  last_idx;

  tx_frame_build #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_build (
    .word     (hold_word),
    .ecc      (hold_ecc),
    .len_code (hold_len),
    .payload  (payload),
    .par_bit  (par_bit),
    .last_idx (last_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      hold_word <= '0;
      hold_ecc  <= 1'b0;
      hold_len  <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      cnt_q     <= '0;
      last_q    <= '0;
      txd_q     <= 1'b1;
      ready_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (!wr_n) begin
          hold_word <= din;
          hold_ecc  <= ecc_mode;
          hold_len  <= len_code;
          ready_q   <= 1'b0;
          state_q   <= ecc_mode ? ST_LDC : ST_LDN;
        end
        ST_LDN, ST_LDC: if (baud_tick) begin
          sh_q    <= payload;
          par_q   <= par_bit;
          last_q  <= last_idx;
          txd_q   <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: if (baud_tick) begin
          txd_q   <= sh_q[0];
          sh_q    <= sh_q >> 1;
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (baud_tick) begin
          if (cnt_q == last_q) begin
            txd_q   <= par_q;
            state_q <= ST_PAR;
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: if (baud_tick) begin
          txd_q   <= 1'b1;
          state_q <= ST_STOP;
        end
        ST_STOP: if (baud_tick) begin
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign txd   = txd_q;
  assign ready = ready_q;

  // R8
  ready_txd_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> txd_q);
  // R3
  hold_txd_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && !baud_tick) |=> $stable(txd_q));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_q |=> ($stable(hold_word) && $stable(hold_ecc) && $stable(hold_len)));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !wr_n) |=> !ready_q);
  // R7
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |-> txd_q);
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> (cnt_q <= last_q));
  // R6
  ldc_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LDC) |-> hold_ecc);
endmodule

// File: tb/tb_uart_sec_tx.sv
`timescale 1ns/1ps
module tb_uart_sec_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic wr_n = 1'b1;
  logic [7:0] din = '0;
  logic ecc_mode = 1'b0;
  logic [1:0] len_code = '0;
  logic txd, ready;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uart_sec_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_n(wr_n), .din(din),
    .ecc_mode(ecc_mode), .len_code(len_code), .txd(txd), .ready(ready)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ham(input logic [3:0] d);
    logic p1, p2, p3, pa;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p3 = d[1] ^ d[2] ^ d[3];
    pa = ^{d, p1, p2, p3};
    return {d, p3, pa, p2, p1};
  endfunction

  function automatic int frame_len(input logic m, input logic [1:0] w);
    return m ? 8 : 5 + int'(w);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic m,
                                             input logic [1:0] w);
    logic [11:0] f;
    logic [7:0] pl;
    logic pb;
    int n;
    n = frame_len(m, w);
    f = '0;
    pb = 1'b0;
    pl = m ? ham(d[3:0]) : d;
    for (int i = 0; i < n; i++) begin
      f[i+1] = pl[i];
      pb ^= pl[i];
    end
    f[n+1] = m ? 1'b1 : pb;
    f[n+2] = 1'b1;
    return f;
  endfunction

  task automatic tick_pulse();
    @(posedge clk); #1 baud_tick = 1'b1;
    @(posedge clk); #1 baud_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d, input logic m, input logic [1:0] w);
    @(posedge clk); #1 wr_n = 1'b0; din = d; ecc_mode = m; len_code = w;
    @(posedge clk); #1 wr_n = 1'b1; din = ~d;
    @(negedge clk);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic m, input logic [1:0] w,
                            input logic [11:0] exp_f, input int intrude_at);
    int n;
    n = frame_len(m, w);
    write_word(d, m, w);
    check("R2 ready low after write", ready, 1'b0);
    idle_clocks(3);
    check("R3 txd held before first tick", txd, 1'b1);
    for (int k = 0; k <= n + 2; k++) begin
      tick_pulse();
      if (k == intrude_at) write_word(~d, ~m, ~w);
      if (k == 0)
        check("R3 start bit", txd, exp_f[k]);
      else if (k <= n)
        check(m ? "R6 codeword bit" : "R4 data bit", txd, exp_f[k]);
      else if (k == n + 1)
        check(m ? "R7 parity slot one" : "R5 even parity", txd, exp_f[k]);
      else
        check("R7 stop bit", txd, exp_f[k]);
      if (intrude_at >= 0 && k > intrude_at)
        check("R9 frame unchanged", txd, exp_f[k]);
    end
    check("R8 ready low during stop", ready, 1'b0);
    tick_pulse();
    check("R8 ready back high", ready, 1'b1);
    check("R8 txd idle high", txd, 1'b1);
    if (intrude_at >= 0) begin
      tick_pulse();
      tick_pulse();
      check("R9 no extra frame txd", txd, 1'b1);
      check("R9 no extra frame ready", ready, 1'b1);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_0DED));
    idle_clocks(1);
    check("R1 txd during reset", txd, 1'b1);
    @(posedge clk); @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1 txd after reset", txd, 1'b1);
    check("R1 ready after reset", ready, 1'b1);

    // R4 / R5: each length code with all ones above the cut
    for (int w = 0; w < 4; w++)
      send_frame(8'hFF, 1'b0, 2'(w), frame_bits(8'hFF, 1'b0, 2'(w)), -1);
    send_frame(8'hA5, 1'b0, 2'b11, frame_bits(8'hA5, 1'b0, 2'b11), -1);
    send_frame(8'hE0, 1'b0, 2'b00, frame_bits(8'hE0, 1'b0, 2'b00), -1);

    // R6: literal codeword for data 0001, junk in upper bits and length code
    send_frame(8'hB1, 1'b1, 2'b00, {1'b1, 1'b1, 8'b00010111, 1'b0}, -1);
    send_frame(8'h00, 1'b1, 2'b10, frame_bits(8'h00, 1'b1, 2'b10), -1);

    // R9: write strobe in the middle of frames
    send_frame(8'h3C, 1'b0, 2'b01, frame_bits(8'h3C, 1'b0, 2'b01), 2);
    send_frame(8'h0B, 1'b1, 2'b11, frame_bits(8'h0B, 1'b1, 2'b11), 5);

    // R1: reset in mid-frame
    write_word(8'h55, 1'b0, 2'b11);
    tick_pulse(); tick_pulse(); tick_pulse();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1 txd after mid-frame reset", txd, 1'b1);
    check("R1 ready after mid-frame reset", ready, 1'b1);
    tick_pulse();
    check("R1 no frame resumes", txd, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      logic m;
      logic [1:0] w;
      d = 8'($urandom);
      m = 1'($urandom);
      w = 2'($urandom);
      send_frame(d, m, w, frame_bits(d, m, w), (i % 5 == 0) ? 1 : -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule